// File: doc/BRIEF.md
# Linked-List Transmit DMA Engine

This engine serves one transmit channel. It walks a chain of four-word descriptors in memory and sends each buffer out as a byte stream. A one-cycle `start` pulse gives it the address of the first descriptor and the address of the channel context word. It fetches the descriptor and reads the buffer one byte at a time, from the current position up to the one-past-end address. When a buffer is finished, it writes the descriptor back in place. It then either follows the next pointer or, at end of list, marks the context as disabled and stops.

Memory is reached through two simple request/response ports, one for reads and one for writes. A request is held, with a stable address (and stable data for writes), until the matching acknowledge is seen at a clock edge. The output is a valid/ready byte stream. Once `out_valid` is high, `out_data` and `out_last` hold steady until a cycle in which `out_ready` is also high. A low `out_ready` simply stalls the engine; no byte is dropped or repeated.

A descriptor at address D has these words: the next pointer at D+0, the buffer start at D+4, the one-past-end address at D+8 and a flag word at D+12. In the flag word, bit 0 requests an interrupt, bit 1 marks end of packet and bit 2 marks end of list.

Top module: `dmo_engine`

## Requirements
- R1: After reset `busy`, `eol_flag`, `raw_intr`, `out_valid`, `rd_req` and `wr_req` are all low.
- R2: On `start` the engine reads the four descriptor words at `desc_addr`+0/4/8/12. It then streams bytes from the buffer start up to one below the one-past-end address, in rising address order. Each byte is fetched by a word read at the address with its two low bits cleared, and byte lane k sits in bits 8k+7:8k. A read request holds its address until acknowledged.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.
- R4: `out_last` is high on the final byte of a buffer exactly when that descriptor's end-of-packet flag (bit 1) is set, and on no other byte.
- R5: A buffer is sent in bursts of at most `MAX_BURST` bytes. At each burst boundary the engine spends one extra cycle working out the next burst length, so with `out_ready` held high and reads acknowledged in one cycle, beats are two cycles apart inside a burst and three cycles apart across a boundary.
- R6: When a buffer is finished, the four descriptor words are written back to the same four addresses in ascending order. The read and write ports are never both requesting.
- R7: If the finished descriptor has the interrupt flag (bit 0), `raw_intr[2]` is set. This happens two cycles after the final beat is accepted, or in the cycle after write-back would begin for an empty buffer. The bit stays set until `intr_clr`.
- R8: If the finished descriptor lacks end of list (bit 2), the engine fetches the descriptor at its next pointer and continues from that descriptor's buffer start.
- R9: If the finished descriptor has end of list, the engine writes the value 1 (disable bit 0) to `ctx_addr` after the write-back, then sets `eol_flag` and drops `busy`.
- R10: While `eol_flag` is set, no memory request and no output beat is made. A `start` clears `eol_flag` and runs a new chain.
- R11: A descriptor whose one-past-end address equals its buffer start produces no beats but is still written back and followed.
- R12: A `start` pulse while `busy` is high has no effect on the running chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chain (ignored while busy) |
| desc_addr | input | ADDR_W | First descriptor address |
| ctx_addr | input | ADDR_W | Channel context word address |
| intr_clr | input | 1 | Clears the data interrupt bit |
| busy | output | 1 | Chain in progress |
| eol_flag | output | 1 | Channel stopped at end of list |
| raw_intr | output | 3 | Raw interrupts; bit 2 is the data interrupt |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Read word address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data word |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | 32 | Write data word |
| wr_ack | input | 1 | Write acknowledge |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output consumer ready |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | End-of-packet marker |

## Verification
The bench's memory answers every request one cycle after it appears. This makes the engine's timing exact, and the bench counts each response from the edge that accepts the last output beat. After that beat, the interrupt bit shows at the second sampling point. With the consumer always ready, beat spacing is two cycles inside a burst and three across a boundary. The bench samples on falling edges and records the cycle number of every accepted beat and of every rise of the interrupt bit. It then compares those numbers against these offsets instead of simply waiting for the end state. Stream contents, the order of write-backs and the context write are compared from logs after the engine goes idle.

// File: rtl/dmo_pkg.sv
package dmo_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned DESC_WORDS = 4;

  // descriptor word slots
  localparam int unsigned W_NEXT  = 0;
  localparam int unsigned W_START = 1;
  localparam int unsigned W_AFTER = 2;
  localparam int unsigned W_FLAGS = 3;

  // flag bits
  localparam int unsigned F_INTR = 0;
  localparam int unsigned F_EOP  = 1;
  localparam int unsigned F_EOL  = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_SPAN,
    S_READ,
    S_BEAT,
    S_WBACK,
    S_CTX
  } dmo_state_e;
endpackage

// File: rtl/dmo_span.sv
module dmo_span #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_BURST = 2048,
  localparam int unsigned CNT_W    = $clog2(MAX_BURST + 1)
) (
  input  logic [ADDR_W-1:0] pos,
  input  logic [ADDR_W-1:0] after,
  output logic              empty,
  output logic [CNT_W-1:0]  blen
);
  logic [ADDR_W-1:0] remain;

  always_comb begin
    remain = after - pos;
    empty  = (remain == '0);
    if (remain > ADDR_W'(MAX_BURST))
      blen = CNT_W'(MAX_BURST);
    else
      blen = remain[CNT_W-1:0];
  end
endmodule

// File: rtl/dmo_lane_pick.sv
module dmo_lane_pick #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned LW   = $clog2(BYTES)
) (
  input  logic [8*BYTES-1:0] word,
  input  logic [LW-1:0]      lane,
  output logic [7:0]         byte_o
);
  logic [7:0] lanes [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign byte_o = lanes[lane];
endmodule

// File: rtl/dmo_engine.sv
module dmo_engine
  import dmo_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_BURST = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [ADDR_W-1:0] ctx_addr,
  input  logic              intr_clr,
  output logic              busy,
  output logic              eol_flag,
  output logic [2:0]        raw_intr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              wr_ack,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int unsigned CNT_W = $clog2(MAX_BURST + 1);
  localparam int unsigned LW    = $clog2(WORD_BYTES);
  localparam int unsigned IW    = $clog2(DESC_WORDS);

  dmo_state_e         state;
  logic [WORD_W-1:0]  dw [DESC_WORDS];
  logic [IW-1:0]      widx;
  logic [ADDR_W-1:0]  sdp, ctx, pos;
  logic [CNT_W-1:0]   cnt;
  logic [7:0]         byte_q;
  logic               eol_q, intr_q;

  logic               span_empty;
  logic [CNT_W-1:0]   span_len;
  logic [7:0]         lane_byte;
  logic [ADDR_W-1:0]  after_a, next_a, start_a, word_off;
  logic [WORD_W-1:0]  flags;

  assign next_a   = dw[W_NEXT][ADDR_W-1:0];
  assign start_a  = dw[W_START][ADDR_W-1:0];
  assign after_a  = dw[W_AFTER][ADDR_W-1:0];
  assign flags    = dw[W_FLAGS];
  assign word_off = ADDR_W'({widx, LW'(0)});

  dmo_span #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) u_span (
    .pos   (pos),
    .after (after_a),
    .empty (span_empty),
    .blen  (span_len)
  );

  dmo_lane_pick #(.BYTES(WORD_BYTES)) u_lane (
    .word   (rd_data),
    .lane   (pos[LW-1:0]),
    .byte_o (lane_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      widx   <= '0;
      sdp    <= '0;
      ctx    <= '0;
      pos    <= '0;
      cnt    <= '0;
      byte_q <= '0;
      eol_q  <= 1'b0;
      intr_q <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) dw[i] <= '0;
    end else begin
      if (intr_clr) intr_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            sdp   <= desc_addr;
            ctx   <= ctx_addr;
            eol_q <= 1'b0;
            widx  <= '0;
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (rd_ack) begin
            dw[widx] <= rd_data;
            if (widx == IW'(DESC_WORDS - 1)) begin
              pos   <= start_a;
              state <= S_SPAN;
            end else begin
              widx <= widx + 1'b1;
            end
          end
        end
        S_SPAN: begin
          if (span_empty) begin
            if (flags[F_INTR]) intr_q <= 1'b1;
            widx  <= '0;
            state <= S_WBACK;
          end else begin
            cnt   <= span_len;
            state <= S_READ;
          end
        end
        S_READ: begin
          if (rd_ack) begin
            byte_q <= lane_byte;
            state  <= S_BEAT;
          end
        end
        S_BEAT: begin
          if (out_ready) begin
            pos   <= pos + ADDR_W'(1);
            cnt   <= cnt - CNT_W'(1);
            state <= (cnt == CNT_W'(1)) ? S_SPAN : S_READ;
          end
        end
        S_WBACK: begin
          if (wr_ack) begin
            if (widx == IW'(DESC_WORDS - 1)) begin
              widx <= '0;
              if (flags[F_EOL]) begin
                state <= S_CTX;
              end else begin
                sdp   <= next_a;
                state <= S_FETCH;
              end
            end else begin
              widx <= widx + 1'b1;
            end
          end
        end
        S_CTX: begin
          if (wr_ack) begin
            eol_q <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req    = (state == S_FETCH) || (state == S_READ);
    rd_addr   = (state == S_FETCH) ? (sdp + word_off)
                                   : {pos[ADDR_W-1:LW], LW'(0)};
    wr_req    = (state == S_WBACK) || (state == S_CTX);
    wr_addr   = (state == S_WBACK) ? (sdp + word_off) : ctx;
    wr_data   = (state == S_WBACK) ? dw[widx] : WORD_W'(1);
    out_valid = (state == S_BEAT);
    out_data  = byte_q;
    out_last  = (state == S_BEAT) && flags[F_EOP] &&
                ((pos + ADDR_W'(1)) == after_a);
    busy      = (state != S_IDLE);
    eol_flag  = eol_q;
    raw_intr  = {intr_q, 2'b00};
  end
endmodule

// File: rtl/dmo_engine_chk.sv
module dmo_engine_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              eol_flag,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ack,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wr_ack,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_last
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req && !out_valid));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=>
      (wr_req && $stable(wr_addr) && $stable(wr_data)));

  p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  p_eol_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eol_flag |-> (!rd_req && !wr_req && !out_valid));
endmodule

bind dmo_engine dmo_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dmo_engine_test.sv
module dmo_engine_test;
  localparam int MAXB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] desc_addr = '0, ctx_addr = '0;
  logic        intr_clr = 1'b0;
  logic        busy, eol_flag;
  logic [2:0]  raw_intr;
  logic        rd_req, wr_req, out_valid, out_last;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic        rd_ack = 1'b0, wr_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;

  always #5 clk = ~clk;

  dmo_engine #(.ADDR_W(32), .MAX_BURST(MAXB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
    .ctx_addr(ctx_addr), .intr_clr(intr_clr), .busy(busy),
    .eol_flag(eol_flag), .raw_intr(raw_intr), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );

  logic [31:0] mem [0:1023];
  int nchk = 0, nerr = 0, cyc = 0;
  logic [7:0] bd [0:511];
  logic       bl [0:511];
  int         bc [0:511];
  int         nb = 0;
  logic [31:0] wa [0:63], wd [0:63];
  int nw = 0, nrd = 0;
  int intr_cyc = -1;
  logic prev_stall = 1'b0, prev_last = 1'b0, prev_intr = 1'b0;
  logic [7:0] prev_data = '0;
  logic bp_mode = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and stream monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    rd_ack <= 1'b0;
    wr_ack <= 1'b0;
    if (rd_req) begin
      rd_ack  <= 1'b1;
      rd_data <= mem[rd_addr[11:2]];
      nrd++;
    end
    if (wr_req) begin
      wr_ack <= 1'b1;
      mem[wr_addr[11:2]] = wr_data;
      if (nw < 64) begin wa[nw] = wr_addr; wd[nw] = wr_data; end
      nw++;
    end
    if (prev_stall)
      check(out_valid && out_data == prev_data && out_last == prev_last,
            "R3 stall hold", {out_valid, out_data}, {1'b1, prev_data});
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    prev_last  = out_last;
    if (out_valid && out_ready && nb < 512) begin
      bd[nb] = out_data; bl[nb] = out_last; bc[nb] = cyc; nb++;
    end
    if (raw_intr[2] && !prev_intr) intr_cyc = cyc;
    prev_intr = raw_intr[2];
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  function automatic logic [7:0] exp_byte(input int a);
    logic [31:0] w;
    w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic put_desc(input int a, input int nx, input int bs, input int af, input int fl);
    mem[a[11:2]]     = nx;
    mem[a[11:2] + 1] = bs;
    mem[a[11:2] + 2] = af;
    mem[a[11:2] + 3] = fl;
  endtask

  task automatic kick(input int d, input int c);
    @(posedge clk); #1;
    start = 1'b1; desc_addr = d; ctx_addr = c;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    check(!busy, "watch idle", busy, 0);
  endtask

  task automatic clear_logs();
    nb = 0; nw = 0; intr_cyc = -1;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(!busy && !eol_flag && raw_intr == 0, "R1 status", {busy, eol_flag, raw_intr}, 0);
    check(!rd_req && !wr_req && !out_valid, "R1 ports", {rd_req, wr_req, out_valid}, 0);
  endtask

  task automatic test_single();
    clear_logs();
    put_desc('h100, 0, 'h403, 'h40b, 6);
    kick('h100, 'h1f0);
    wait_idle();
    check(nb == 8, "R2 beat count", nb, 8);
    for (int i = 0; i < 8; i++) begin
      check(bd[i] == exp_byte('h403 + i), "R2 byte", bd[i], exp_byte('h403 + i));
      check(bl[i] == (i == 7), "R4 last", bl[i], (i == 7));
    end
    check(nw == 5, "R6 write count", nw, 5);
    for (int i = 0; i < 4; i++)
      check(wa[i] == 'h100 + 4 * i, "R6 wb addr", wa[i], 'h100 + 4 * i);
    check(wd[1] == 'h403 && wd[2] == 'h40b && wd[3] == 6, "R6 wb data", wd[3], 6);
    check(wa[4] == 'h1f0 && wd[4] == 1, "R9 ctx write", wd[4], 1);
    check(eol_flag && !busy, "R9 stopped", {eol_flag, busy}, 2'b10);
    check(raw_intr == 0, "R7 no intr", raw_intr, 0);
  endtask

  task automatic test_quiet();
    int r0, w0, b0;
    r0 = nrd; w0 = nw; b0 = nb;
    repeat (20) @(negedge clk);
    check(nrd == r0 && nw == w0 && nb == b0, "R10 quiet", nrd - r0 + nw - w0, 0);
    check(eol_flag, "R10 flag kept", eol_flag, 1);
  endtask

  task automatic test_chain();
    int e;
    clear_logs();
    bp_mode = 1'b1;
    put_desc('h120, 'h140, 'h500, 'h505, 1);
    put_desc('h140, 'h160, 'h600, 'h600, 0);
    put_desc('h160, 0, 'h702, 'h708, 7);
    kick('h120, 'h1f4);
    check(!eol_flag && busy, "R10 start clears", {eol_flag, busy}, 2'b01);
    repeat (10) @(posedge clk);
    #1; start = 1'b1; desc_addr = 'h100;
    @(posedge clk); #1; start = 1'b0;
    wait_idle();
    bp_mode = 1'b0;
    check(nb == 11, "R8 beat count", nb, 11);
    for (int i = 0; i < 11; i++) begin
      e = (i < 5) ? exp_byte('h500 + i) : exp_byte('h702 + i - 5);
      check(bd[i] == e, "R12 R8 byte", bd[i], e);
      check(bl[i] == (i == 10), "R4 chain last", bl[i], (i == 10));
    end
    check(nw == 13, "R11 write count", nw, 13);
    for (int i = 0; i < 12; i++) begin
      e = (i < 4) ? 'h120 + 4 * i : (i < 8) ? 'h140 + 4 * (i - 4) : 'h160 + 4 * (i - 8);
      check(wa[i] == e, "R6 R11 wb order", wa[i], e);
    end
    check(wa[12] == 'h1f4 && wd[12] == 1, "R9 ctx", wa[12], 'h1f4);
    check(raw_intr[2], "R7 intr set", raw_intr, 4);
    @(posedge clk); #1; intr_clr = 1'b1;
    @(posedge clk); #1; intr_clr = 1'b0;
    @(negedge clk);
    check(raw_intr == 0, "R7 intr clear", raw_intr, 0);
  endtask

  task automatic test_intr_timing();
    clear_logs();
    put_desc('h180, 0, 'h800, 'h803, 5);
    kick('h180, 'h1f8);
    wait_idle();
    check(nb == 3, "R7 beats", nb, 3);
    check(intr_cyc == bc[2] + 2, "R7 intr cycle", intr_cyc - bc[2], 2);
  endtask

  task automatic test_burst();
    int d;
    clear_logs();
    put_desc('h1a0, 0, 'h900, 'h914, 6);
    kick('h1a0, 'h1fc);
    wait_idle();
    check(nb == 20, "R5 beats", nb, 20);
    for (int i = 1; i < 20; i++) begin
      d = ((i % MAXB) == 0) ? 3 : 2;
      check(bc[i] - bc[i-1] == d, "R5 spacing", bc[i] - bc[i-1], d);
    end
    check(bl[19] && !bl[7] && !bl[15], "R4 burst last", bl[19], 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++)
      for (int k = 0; k < 4; k++)
        mem[i][8*k +: 8] = 8'((4 * i + k) * 13 + 5);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_single();
    test_quiet();
    test_chain();
    test_intr_timing();
    test_burst();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule